// File: doc/BRIEF.md
# Full-Speed USB Receive Deserializer

This block turns a full-speed USB line-state stream, already sampled once per bit time, into packet bytes for the link-side logic. A sample is taken on each cycle where the bit strobe is high. The block searches the NRZI-decoded stream for the packet lead-in pattern and removes it. It drops the zero inserted after each run of six ones and shifts the remaining bits into bytes, least significant bit first. It closes the packet on the end-of-packet line state.

While a packet is in progress the block holds an activity output high. It pulses a byte strobe once for each byte it completes. It pulses separate error outputs for three conditions: a stuffing violation, which also aborts the packet; a packet that ends part-way through a byte; and an elasticity-buffer fault reported by the sampling logic upstream, which is forwarded while a packet is active.

Top module: `usb_rx_deser`

## Requirements
- R1: While rst_ni is low, every output is zero. The line level remembered for decoding is J (line_i[1] = 1).
- R2: line_i[1] is D+ and line_i[0] is D-. The value 2'b00 is SE0. Any other value has level line_i[1], where 1 is J and 0 is K. A non-SE0 sample decodes to 1 when its level equals the previous non-SE0 level, and to 0 when it differs.
- R3: While the block is hunting, a decoded 1 that follows at least SYNC_ZEROS (4) consecutive decoded 0s completes the lead-in pattern. rx_active_o rises one cycle after that sample. No bit of the lead-in pattern is ever delivered as data.
- R4: Data bits fill a byte starting at bit 0. One cycle after the sample that supplies the eighth data bit, rx_valid_o is high for exactly one cycle, rx_data_o holds the byte, and rx_active_o is high.
- R5: The final 1 of the lead-in pattern counts toward the run of ones. After six consecutive decoded 1s, a following decoded 0 is dropped and the run restarts.
- R6: A decoded 1 after six consecutive 1s is a stuffing error. One cycle later stuff_err_o pulses and rx_active_o is low. No byte is delivered from that sample, and the block returns to hunting.
- R7: Inside a packet, two or more consecutive SE0 samples followed by a non-SE0 sample end the packet, and rx_active_o falls one cycle later. A single SE0 sample between data samples carries no bit and is otherwise ignored.
- R8: If the sample that ends a packet arrives while a partial byte (1 to 7 bits) is held, align_err_o pulses together with the fall of rx_active_o.
- R9: eb_err_o is high in the cycle after eb_err_i was high while a packet was active. eb_err_i has no effect while the block is hunting.
- R10: On a cycle where bit_vld_i is low, line_i is ignored and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | High when line_i holds a new bit-time sample |
| line_i | input | 2 | Sampled line state {D+, D-} |
| eb_err_i | input | 1 | Elasticity-buffer overrun or underrun from the sampler |
| rx_active_o | output | 1 | High for the duration of a received packet |
| rx_valid_o | output | 1 | One-cycle strobe for each completed byte |
| rx_data_o | output | DATA_W | Last completed byte |
| stuff_err_o | output | 1 | Stuffing violation pulse; the packet is aborted |
| align_err_o | output | 1 | Packet ended on a non-byte boundary |
| eb_err_o | output | 1 | Forwarded elasticity-buffer error |

## Verification
The hardest cases to reach are the ones where several run lengths line up. One is a stuffed zero that falls exactly on a byte boundary. Another is a run of ones that continues from the lead-in pattern into the first data byte. To reach them, the stimulus sends back-to-back 0xFF bytes right after the lead-in, with its own stuffer seeded by that trailing one. A stuffing error is produced by switching the bench stuffer off in the middle of a packet. A single stray SE0 sample and bit-strobe gaps carrying garbage line values are placed inside bytes, so that they fall between data samples.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic {ST_HUNT, ST_PKT} rx_state_e;
  localparam logic [1:0] LINE_SE0 = 2'b00;
endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi
  import usb_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic [1:0] line_i,
  output logic       se0_o,
  output logic       bit_o
);
  logic prev_q;
  logic lvl;

  assign lvl   = line_i[1];
  assign se0_o = (line_i == LINE_SE0);
  assign bit_o = (lvl == prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              prev_q <= 1'b1;
    else if (smp_i && !se0_o) prev_q <= lvl;
  end

  assert_hold_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_i |=> $stable(prev_q));
endmodule

// File: rtl/usb_rx_destuff.sv
module usb_rx_destuff #(
  parameter int RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic drop_o,
  output logic err_o
);
  localparam int OW = $clog2(RUN + 1);
  localparam logic [OW-1:0] OMAX = OW'(RUN);

  logic [OW-1:0] ones_q;
  logic          full;

  assign full   = (ones_q == OMAX);
  assign drop_o = bit_en_i && full && !bit_i;
  assign err_o  = bit_en_i && full && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ones_q <= '0;
    else if (load_i)   ones_q <= OW'(1);  // trailing one of lead-in
    else if (bit_en_i) begin
      if (full)       ones_q <= '0;
      else if (bit_i) ones_q <= ones_q + 1'b1;
      else            ones_q <= '0;
    end
  end

  assert_run_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= OMAX);
  assert_drop_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o && !load_i |=> ones_q == '0);
endmodule

// File: rtl/usb_rx_bytes.sv
module usb_rx_bytes #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_o,
  output logic         done_o,
  output logic         partial_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] CLAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  assign byte_o    = {bit_i, sr_q[W-1:1]};
  assign done_o    = shift_i && (cnt_q == CLAST);
  assign partial_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= byte_o;
      cnt_q <= (cnt_q == CLAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CLAST);
endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
  import usb_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYNC_ZEROS = 4,
  parameter int STUFF_RUN  = 6,
  parameter int EOP_SE0    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic [1:0]        line_i,
  input  logic              eb_err_i,
  output logic              rx_active_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              stuff_err_o,
  output logic              align_err_o,
  output logic              eb_err_o
);
  localparam int ZW = $clog2(SYNC_ZEROS + 1);
  localparam int SW = $clog2(EOP_SE0 + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(SYNC_ZEROS);
  localparam logic [SW-1:0] SMAX = SW'(EOP_SE0);

  rx_state_e state_q;
  logic [ZW-1:0] zeros_q;
  logic [SW-1:0] se0_q;

  logic se0, dbit, in_pkt;
  logic hunt_bit, sync_hit, eop_hit, data_bit, shift;
  logic drop, serr, bdone, bpart;
  logic [DATA_W-1:0] bval;

  usb_rx_nrzi u_nrzi (
    .clk_i, .rst_ni, .smp_i(bit_vld_i), .line_i, .se0_o(se0), .bit_o(dbit)
  );

  assign in_pkt   = (state_q == ST_PKT);
  assign hunt_bit = bit_vld_i && !in_pkt && !se0;
  assign sync_hit = hunt_bit && dbit && (zeros_q == ZMAX);
  assign eop_hit  = bit_vld_i && in_pkt && !se0 && (se0_q == SMAX);
  assign data_bit = bit_vld_i && in_pkt && !se0 && !eop_hit;
  assign shift    = data_bit && !drop && !serr;

  usb_rx_destuff #(.RUN(STUFF_RUN)) u_destuff (
    .clk_i, .rst_ni, .load_i(sync_hit), .bit_en_i(data_bit), .bit_i(dbit),
    .drop_o(drop), .err_o(serr)
  );

  usb_rx_bytes #(.W(DATA_W)) u_bytes (
    .clk_i, .rst_ni, .clr_i(sync_hit), .shift_i(shift), .bit_i(dbit),
    .byte_o(bval), .done_o(bdone), .partial_o(bpart)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      zeros_q <= '0;
      se0_q   <= '0;
    end else begin
      if (sync_hit)              state_q <= ST_PKT;
      else if (eop_hit || serr)  state_q <= ST_HUNT;

      if (eop_hit || serr || sync_hit) zeros_q <= '0;
      else if (hunt_bit)         zeros_q <= dbit ? '0 : ((zeros_q == ZMAX) ? zeros_q : zeros_q + 1'b1);
      else if (bit_vld_i && !in_pkt) zeros_q <= '0;  // SE0 while hunting

      if (sync_hit || eop_hit)   se0_q <= '0;
      else if (bit_vld_i && in_pkt)
        se0_q <= se0 ? ((se0_q == SMAX) ? se0_q : se0_q + 1'b1) : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o  <= 1'b0;
      rx_data_o   <= '0;
      stuff_err_o <= 1'b0;
      align_err_o <= 1'b0;
      eb_err_o    <= 1'b0;
    end else begin
      rx_valid_o  <= bdone;
      if (bdone) rx_data_o <= bval;
      stuff_err_o <= serr;
      align_err_o <= eop_hit && bpart;
      eb_err_o    <= eb_err_i && in_pkt;
    end
  end

  assign rx_active_o = in_pkt;

  assert_valid_in_pkt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_active_o);
  assert_stuff_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> !rx_active_o && !rx_valid_o);
  assert_align_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> $fell(rx_active_o));
  assert_eb_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eb_err_o |-> $past(eb_err_i));
  assert_idle_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(rx_active_o) && !rx_valid_o);
endmodule

// File: tb/usb_rx_deser_bench.sv
`timescale 1ns/1ps
module usb_rx_deser_bench;
  localparam logic [1:0] J = 2'b10, K = 2'b01, SE0 = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, eb = 1'b0;
  logic [1:0] line = J;
  logic act, val, serr, aerr, eerr;
  logic [7:0] data;

  always #2 clk = ~clk;

  usb_rx_deser u_usb_rx_deser (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(vld), .line_i(line), .eb_err_i(eb),
    .rx_active_o(act), .rx_valid_o(val), .rx_data_o(data),
    .stuff_err_o(serr), .align_err_o(aerr), .eb_err_o(eerr)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // behavioural reference model
  int m_prev, m_pkt, m_zeros, m_ones, m_bits, m_sr, m_se0;
  int e_act, e_val, e_data, e_serr, e_aerr, e_eerr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 1; m_pkt = 0; m_zeros = 0; m_ones = 0; m_bits = 0; m_sr = 0; m_se0 = 0;
      e_act = 0; e_val = 0; e_data = 0; e_serr = 0; e_aerr = 0; e_eerr = 0;
    end else begin
      e_val = 0; e_serr = 0; e_aerr = 0;
      e_eerr = (eb && m_pkt) ? 1 : 0;
      if (vld) begin
        int lv, d;
        lv = line[1];
        if (m_pkt == 0) begin
          if (line == SE0) m_zeros = 0;
          else begin
            d = (lv == m_prev); m_prev = lv;
            if (d == 0) m_zeros++;
            else begin
              if (m_zeros >= 4) begin
                m_pkt = 1; m_ones = 1; m_bits = 0; m_se0 = 0;
              end
              m_zeros = 0;
            end
          end
        end else if (line == SE0) m_se0++;
        else if (m_se0 >= 2) begin
          m_prev = lv; m_pkt = 0; m_zeros = 0; m_se0 = 0;
          e_aerr = (m_bits != 0);
        end else begin
          m_se0 = 0;
          d = (lv == m_prev); m_prev = lv;
          if (m_ones == 6) begin
            if (d == 0) m_ones = 0;
            else begin e_serr = 1; m_pkt = 0; m_zeros = 0; end
          end else begin
            m_sr = (m_sr >> 1) | (d << 7);
            m_bits++;
            if (m_bits == 8) begin e_val = 1; e_data = m_sr; m_bits = 0; end
            m_ones = d ? m_ones + 1 : 0;
          end
        end
      end
      e_act = m_pkt;
    end
  end

  // per-cycle comparison and directed byte checks
  byte exp_q[$];
  int n_serr = 0, n_aerr = 0, n_eerr = 0;
  always @(negedge clk) if (rst_n && !finished) begin
    chk(act == e_act[0], "R3/R7 active", act, e_act);
    chk(val == e_val[0], "R4 valid", val, e_val);
    chk(data == e_data[7:0], "R4 data", data, e_data);
    chk(serr == e_serr[0], "R6 stuff_err", serr, e_serr);
    chk(aerr == e_aerr[0], "R8 align_err", aerr, e_aerr);
    chk(eerr == e_eerr[0], "R9 eb_err", eerr, e_eerr);
    if (serr) n_serr++;
    if (aerr) n_aerr++;
    if (eerr) n_eerr++;
    if (val) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected byte", data, 0);
      else begin
        byte e;
        e = exp_q.pop_front();
        chk(data == e, "R2/R4/R5 byte", data, e);
      end
    end
  end

  // stimulus
  int cur = 1, ones = 0;
  task automatic drive(input logic [1:0] ln);
    @(negedge clk); line = ln; vld = 1'b1;
  endtask
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vld = 1'b0; line = 2'(i * 3 + 1);
    end
  endtask
  task automatic raw_bit(input int b);
    if (b == 0) cur = 1 - cur;
    drive(cur ? J : K);
  endtask
  task automatic tx_bit(input int b, input bit stuff);
    raw_bit(b);
    ones = b ? ones + 1 : 0;
    if (stuff && ones == 6) begin raw_bit(0); ones = 0; end
  endtask
  task automatic tx_sync();
    for (int i = 0; i < 7; i++) raw_bit(0);
    raw_bit(1);
    ones = 1;
  endtask
  task automatic tx_byte(input byte b, input bit gaps);
    exp_q.push_back(b);
    for (int i = 0; i < 8; i++) begin
      tx_bit(b[i], 1);
      if (gaps && i == 3) gap(2);
    end
  endtask
  task automatic tx_eop();
    drive(SE0); drive(SE0); drive(J); cur = 1;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(J);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(act == 0 && val == 0 && serr == 0 && aerr == 0 && eerr == 0 && data == 0,
        "R1 reset outputs", {act, val, serr, aerr, eerr}, 0);
    rst_n = 1'b1;
    idle(4);
    // plain packet
    tx_sync(); tx_byte(8'hA5, 0); tx_byte(8'h00, 0); tx_byte(8'h3C, 0); tx_eop();
    idle(3);
    // stuffing across the lead-in and byte boundaries, with strobe gaps (R5, R10)
    tx_sync(); tx_byte(8'hFF, 1); tx_byte(8'hFF, 0); tx_byte(8'h7E, 1); tx_eop();
    gap(3); idle(2);
    // single SE0 inside a byte is ignored (R7)
    tx_sync();
    exp_q.push_back(8'h96);
    for (int i = 0; i < 8; i++) begin
      tx_bit(int'((8'h96 >> i) & 1), 1);
      if (i == 4) drive(SE0);
    end
    tx_eop(); idle(3);
    // stuffing error (R6)
    tx_sync(); tx_byte(8'h12, 0);
    for (int i = 0; i < 7; i++) tx_bit(1, 0);
    idle(4); tx_eop(); idle(3);
    chk(n_serr == 1, "R6 stuff error count", n_serr, 1);
    // mid-byte end (R8)
    tx_sync(); tx_byte(8'h81, 0);
    tx_bit(1, 1); tx_bit(0, 1); tx_bit(1, 1);
    tx_eop(); idle(2);
    chk(n_aerr == 1, "R8 align error count", n_aerr, 1);
    // elasticity error inside and outside a packet (R9)
    @(negedge clk); eb = 1'b1; line = J; vld = 1'b1;
    @(negedge clk); eb = 1'b0;
    tx_sync();
    @(negedge clk); eb = 1'b1; vld = 1'b0;
    @(negedge clk); eb = 1'b0;
    tx_byte(8'h5A, 0);
    @(negedge clk); eb = 1'b1; vld = 1'b0;
    @(negedge clk); eb = 1'b0;
    tx_eop(); idle(3);
    vld = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_eerr == 2, "R9 eb error count", n_eerr, 2);
    chk(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule